// File: doc/BRIEF.md
# Buffered Fast-Program Sequencer

This controller runs the buffered accelerated programming phase of a NOR-style flash command interface. Once the phase is opened, the host fills a word buffer over an ordinary write bus, one slot per write. The slot index is the low bits of the write address, and the upper address bits select an erase block. A write to the buffer's last slot closes the load. The sequencer then moves the buffered words, slot 0 first, into consecutive array addresses through a request/done write port. A busy bit in an eight-bit status word is set for as long as this drain is running. Each new load picks up at the array address just after the last word of the previous load.

The host leaves the phase by writing to an address in a different block. That write should carry the all-ones word. If it carries any other value, an error flag is raised, but the phase still ends. The sequencer passes through a one-cycle exit state into idle, and a ready bit reports that normal operation has resumed. Any write the host makes while a drain is running is dropped without effect, even a write that would otherwise end the phase. Opening the phase is done by a single strobe, which takes the target block from the address bus.

States: `ST_IDLE` (normal operation, ready), `ST_FILL` (accepting buffer writes), `ST_DRAIN` (moving words to the array), `ST_EXIT` (one cycle after a block change). Transitions:
- open: `ST_IDLE`→`ST_FILL` on `phase_start`.
- load-full: `ST_FILL`→`ST_DRAIN` on a write to the last slot of the current block.
- leave: `ST_FILL`→`ST_EXIT` on a write to another block.
- drained: `ST_DRAIN`→`ST_FILL` on the done pulse of the last slot.
- resume: `ST_EXIT`→`ST_IDLE` unconditionally.

Top module: `fps_seq`

## Requirements
- R1: After reset, `status` reads 0x80 (bit 7 ready set, all other bits clear) and `arr_req` is low.
- R2: A `phase_start` strobe in idle opens the phase. From the next cycle `status` reads 0x00. The block number is taken from `host_addr[AW-1:BLK_AW]`, and the first drained word goes to that block's base address (offset 0).
- R3: A host write to the current block whose slot index `host_addr[IW-1:0]` equals DEPTH-1 stores that word and starts a drain. `status` bit 0 is set from the next cycle and stays set until the cycle after the done pulse of the last slot.
- R4: A drain presents slots 0 to DEPTH-1 in order on consecutive values of `arr_addr`, one word for each `arr_done` pulse.
- R5: Each load continues at the array address immediately after the last word of the previous load.
- R6: Host writes made while `status` bit 0 is set are ignored. They change neither buffer contents nor the phase, and this includes a write that coincides with the final done pulse.
- R7: A host write to a different block with data 0xFFFF ends the phase. From the next cycle `status` reads 0x80.
- R8: A block-change write with data other than 0xFFFF also ends the phase, but sets `status` bit 4. Bit 4 stays set until the next accepted `phase_start`, which clears it.
- R9: A `phase_start` strobe is accepted again after exit. A strobe while the phase is open has no effect: the block and the address sequence stay the same.
- R10: While `arr_req` is high and no done pulse has arrived, `arr_req`, `arr_addr` and `arr_data` hold steady.
- R11: Host writes in idle are ignored: no array request, and `status` stays 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_start | input | 1 | Opens the phase; block taken from `host_addr` |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host write address (block, slot) |
| host_data | input | DW | Host write data |
| arr_req | output | 1 | Array write request, held until done |
| arr_addr | output | AW | Array word address |
| arr_data | output | DW | Array word data |
| arr_done | input | 1 | One-cycle completion pulse from the array |
| status | output | 8 | Bit 7 ready, bit 4 error, bit 0 busy |

## Verification
Two events can land in the same cycle: a host write and the final `arr_done` pulse that ends a drain. The bench watches the array port, and in the very cycle the last done pulse is high it drives a block-change write carrying 0xFFFF. The design is judged correct if that write is dropped: one cycle later the status must read 0x00 (phase still open, not busy), and the next load must still drain to the addresses that follow on. Earlier writes made in the middle of a drain, including one to slot 0, are judged by the array log: the slot must still hold its original word.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_EXIT  = 2'd3
    } fps_state_e;

    localparam int STAT_BUSY  = 0;
    localparam int STAT_ERR   = 4;
    localparam int STAT_READY = 7;
endpackage

// File: rtl/fps_buffer.sv
module fps_buffer #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slots [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (wr_en && (32'(wr_idx) < DEPTH)) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (32'(rd_idx) < DEPTH) ? slots[rd_idx] : '0;
endmodule

// File: rtl/fps_ptr.sv
module fps_ptr #(
    parameter int DEPTH  = 32,
    parameter int AW     = 22,
    parameter int BLK_AW = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int BW    = AW - BLK_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] load_blk,
    input  logic          step,
    output logic [BW-1:0] cur_blk,
    output logic [AW-1:0] ptr,
    output logic [IW-1:0] idx,
    output logic          idx_last
);
    assign idx_last = (idx == IW'(DEPTH - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_blk <= '0;
            ptr     <= '0;
            idx     <= '0;
        end else if (load) begin
            cur_blk <= load_blk;
            ptr     <= {load_blk, {BLK_AW{1'b0}}};
            idx     <= '0;
        end else if (step) begin
            ptr <= ptr + 1'b1;
            idx <= idx_last ? '0 : idx + 1'b1;
        end
    end
endmodule

// File: rtl/fps_fsm.sv
module fps_fsm
    import fps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_start,
    input  logic       host_we,
    input  logic       blk_match,
    input  logic       slot_last,
    input  logic       data_ones,
    input  logic       arr_done,
    input  logic       idx_last,
    output fps_state_e state,
    output logic       err,
    output logic       load,
    output logic       buf_we,
    output logic       step
);
    fps_state_e nxt;
    logic       err_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            if (load)         err <= 1'b0;
            else if (err_set) err <= 1'b1;
        end
    end

    always_comb begin
        nxt     = state;
        load    = 1'b0;
        buf_we  = 1'b0;
        step    = 1'b0;
        err_set = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (phase_start) begin
                    load = 1'b1;
                    nxt  = ST_FILL;
                end
            end
            ST_FILL: begin
                if (host_we) begin
                    if (blk_match) begin
                        buf_we = 1'b1;
                        if (slot_last) nxt = ST_DRAIN;
                    end else begin
                        err_set = !data_ones;
                        nxt     = ST_EXIT;
                    end
                end
            end
            ST_DRAIN: begin
                if (arr_done) begin
                    step = 1'b1;
                    if (idx_last) nxt = ST_FILL;
                end
            end
            ST_EXIT: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fps_seq.sv
module fps_seq
    import fps_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DW     = 16,
    parameter int AW     = 22,
    parameter int BLK_AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_start,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_data,
    output logic          arr_req,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_data,
    input  logic          arr_done,
    output logic [7:0]    status
);
    localparam int IW = $clog2(DEPTH);
    localparam int BW = AW - BLK_AW;

    fps_state_e    state;
    logic          err, load, buf_we, step, idx_last;
    logic [BW-1:0] cur_blk;
    logic [IW-1:0] idx;
    logic          blk_match, slot_last, data_ones;
    logic [BLK_AW-1:0] unused_mid;

    assign unused_mid = host_addr[BLK_AW-1:0];
    assign blk_match  = (host_addr[AW-1:BLK_AW] == cur_blk);
    assign slot_last  = (host_addr[IW-1:0] == IW'(DEPTH - 1));
    assign data_ones  = &host_data;

    fps_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .phase_start(phase_start), .host_we(host_we),
        .blk_match(blk_match), .slot_last(slot_last), .data_ones(data_ones),
        .arr_done(arr_done), .idx_last(idx_last),
        .state(state), .err(err), .load(load), .buf_we(buf_we), .step(step)
    );

    fps_ptr #(.DEPTH(DEPTH), .AW(AW), .BLK_AW(BLK_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .load(load), .load_blk(host_addr[AW-1:BLK_AW]), .step(step),
        .cur_blk(cur_blk), .ptr(arr_addr), .idx(idx), .idx_last(idx_last)
    );

    fps_buffer #(.DEPTH(DEPTH), .DW(DW)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_we), .wr_idx(host_addr[IW-1:0]), .wr_data(host_data),
        .rd_idx(idx), .rd_data(arr_data)
    );

    assign arr_req = (state == ST_DRAIN);

    always_comb begin
        status             = '0;
        status[STAT_BUSY]  = (state == ST_DRAIN);
        status[STAT_ERR]   = err;
        status[STAT_READY] = (state == ST_IDLE) || (state == ST_EXIT);
    end
endmodule

// File: rtl/fps_seq_chk.sv
module fps_seq_chk #(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          phase_start,
    input logic          host_we,
    input logic          busy,
    input logic          err,
    input logic          ready,
    input logic          arr_req,
    input logic [AW-1:0] arr_addr,
    input logic [DW-1:0] arr_data,
    input logic          arr_done
);
    // R1: no array traffic while the block reports ready
    p_ready_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !arr_req);
    // R3: a drain only begins after a host write
    p_drain_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(host_we));
    // R4: consecutive words go to consecutive addresses
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && arr_done) |=> (!arr_req || arr_addr == $past(arr_addr) + 1'b1));
    // R6: a write during a drain never ends the phase
    p_drain_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we) |=> !ready);
    // R7: ready only returns because of a host write
    p_exit_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(host_we));
    // R8: the error flag is sticky until a new phase opens
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !phase_start) |=> err);
    // R10: request, address and data hold until done
    p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_req && !arr_done) |=> (arr_req && $stable(arr_addr) && $stable(arr_data)));
endmodule

bind fps_seq fps_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .phase_start(phase_start), .host_we(host_we),
    .busy(status[0]), .err(status[4]), .ready(status[7]),
    .arr_req(arr_req), .arr_addr(arr_addr), .arr_data(arr_data), .arr_done(arr_done)
);

// File: tb/sim_fps_seq.sv
module sim_fps_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 32;
    localparam int DW     = 16;
    localparam int AW     = 22;
    localparam int BLK_AW = 16;
    localparam int LAT    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          phase_start = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_data = '0;
    logic          arr_req;
    logic [AW-1:0] arr_addr;
    logic [DW-1:0] arr_data;
    logic          arr_done = 1'b0;
    logic [7:0]    status;

    int n_chk = 0;
    int n_bad = 0;

    logic [AW-1:0] log_addr [128];
    logic [DW-1:0] log_data [128];
    int            log_n = 0;
    int            cnt = 0;
    logic [AW-1:0] first_addr;
    logic [DW-1:0] first_data;
    int            unstable = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fps_seq #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .BLK_AW(BLK_AW)) u0 (
        .clk(clk), .rst_n(rst_n), .phase_start(phase_start),
        .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
        .arr_req(arr_req), .arr_addr(arr_addr), .arr_data(arr_data),
        .arr_done(arr_done), .status(status)
    );

    // array model: done pulse LAT cycles after a request is seen
    always @(posedge clk) begin
        if (!arr_req || arr_done) begin
            arr_done <= 1'b0;
            cnt      <= 0;
        end else if (cnt == 0) begin
            first_addr <= arr_addr;
            first_data <= arr_data;
            cnt        <= 1;
        end else if (cnt == LAT) begin
            if (arr_addr != first_addr || arr_data != first_data) unstable <= unstable + 1;
            arr_done <= 1'b1;
            if (log_n < 128) begin
                log_addr[log_n] <= arr_addr;
                log_data[log_n] <= arr_data;
            end
            log_n <= log_n + 1;
        end else begin
            cnt <= cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic write_now(input logic [AW-1:0] a, input logic [DW-1:0] d);
        host_we = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        write_now(a, d);
    endtask

    task automatic open_phase(input int blk);
        @(negedge clk);
        phase_start = 1'b1; host_addr = AW'(blk) << BLK_AW;
        @(negedge clk);
        phase_start = 1'b0;
    endtask

    function automatic logic [AW-1:0] slot_addr(input int blk, input int s);
        return (AW'(blk) << BLK_AW) | AW'(s);
    endfunction

    task automatic wait_drain();
        for (int i = 0; i < 2000 && status[0]; i++) @(negedge clk);
    endtask

    task automatic check_log(input int from, input logic [AW-1:0] base,
                             input logic [DW-1:0] dbase, input string req);
        for (int i = 0; i < DEPTH; i++) begin
            check(log_addr[from+i] == base + AW'(i), req, log_addr[from+i], base + AW'(i));
            check(log_data[from+i] == dbase + DW'(i), "R4 data", log_data[from+i], dbase + DW'(i));
        end
    endtask

    task automatic t_reset();
        check(status == 8'h80, "R1 status", status, 8'h80);
        check(arr_req == 1'b0, "R1 req", arr_req, 0);
    endtask

    task automatic t_idle_write();
        host_write(slot_addr(3, DEPTH-1), 16'h5555);
        repeat (LAT + 3) @(negedge clk);
        check(status == 8'h80, "R11 status", status, 8'h80);
        check(log_n == 0, "R11 no array write", log_n, 0);
    endtask

    task automatic t_first_load();
        open_phase(3);
        check(status == 8'h00, "R2 opened", status, 8'h00);
        open_phase(5); // R9: ignored while open
        for (int i = 0; i < DEPTH - 1; i++) host_write(slot_addr(3, i), 16'h1000 + DW'(i));
        host_write(slot_addr(3, DEPTH-1), 16'h1000 + DW'(DEPTH-1));
        check(status == 8'h01, "R3 busy", status, 8'h01);
        host_write(slot_addr(3, 0), 16'hDEAD);   // R6: dropped
        host_write(slot_addr(4, 0), 16'hFFFF);   // R6: dropped
        check(status == 8'h01, "R6 still busy", status, 8'h01);
        wait_drain();
        check(status == 8'h00, "R3 busy cleared", status, 8'h00);
        check(log_n == DEPTH, "R4 count", log_n, DEPTH);
        check(log_addr[0] == slot_addr(3, 0), "R2 base R9", log_addr[0], slot_addr(3, 0));
        check_log(0, slot_addr(3, 0), 16'h1000, "R4 addr");
    endtask

    task automatic t_second_load_collide();
        for (int i = 0; i < DEPTH; i++) host_write(slot_addr(3, i), 16'h2000 + DW'(i));
        for (int i = 0; i < 4000 && !(arr_done && log_n == 2*DEPTH); i++) @(negedge clk);
        write_now(slot_addr(4, 0), 16'hFFFF);    // same cycle as final done
        check(status == 8'h00, "R6 collide", status, 8'h00);
        check(log_n == 2*DEPTH, "R5 count", log_n, 2*DEPTH);
        check_log(DEPTH, slot_addr(3, DEPTH), 16'h2000, "R5 addr");
    endtask

    task automatic t_exit_ok();
        host_write(slot_addr(4, 0), 16'hFFFF);
        check(status == 8'h80, "R7 exit", status, 8'h80);
        @(negedge clk);
        check(status == 8'h80, "R7 idle", status, 8'h80);
    endtask

    task automatic t_exit_err();
        open_phase(7);
        check(status == 8'h00, "R9 reopen", status, 8'h00);
        host_write(slot_addr(1, 0), 16'h1234);
        check(status == 8'h90, "R8 err exit", status, 8'h90);
        repeat (3) @(negedge clk);
        check(status == 8'h90, "R8 sticky", status, 8'h90);
        open_phase(2);
        check(status == 8'h00, "R8 cleared", status, 8'h00);
        host_write(slot_addr(0, 0), 16'hFFFF);
        check(status == 8'h80, "R7 second exit", status, 8'h80);
        check(unstable == 0, "R10 stable request", unstable, 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_write();
        t_first_load();
        t_second_load_collide();
        t_exit_ok();
        t_exit_err();
        finish_run();
    end
endmodule